// File: doc/BRIEF.md
# Frame-Synchronous Shadow Parameter Bank

This block holds the programmable parameters of a video scaler: the two shrink factors, the input aperture rectangle, the output size, the coefficient set selection and four start phases. The host writes them into a shadow bank at any time. The filter datapath only ever sees a separate active bank. Values move from the shadow bank to the active bank only at the start of a vertical blanking interval, and only if the host asked for the move. A half-programmed parameter set therefore never reaches a frame in progress.

The host asks for a transfer by setting an update bit in the control word. On the first clock where vertical blanking is seen asserted, the whole shadow bank is copied, the update bit clears itself, and an update-done interrupt goes high. The interrupt stays high until blanking ends. The scaler enable bit is sampled at that same frame boundary, so scaling starts or stops on whole frames. A frame-done status flag records that an enabled frame has ended. The host port is a plain address/data strobe interface with reads returned one cycle later.

Top module: `scl_shadow_ctrl`

## Requirements
- R1: After reset, the active horizontal and vertical shrink factors read 2^20, which means a ratio of 1.0 with 20 fractional bits. Every other active field is 0. `scale_enable`, `frame_done` and `irq_update` are 0. The shadow shrink factors at 0x10 and 0x14 read 0x0010_0000, and the control word at 0x00 reads 0.
- R2: Host writes update the shadow bank, and a read returns the shadow value on `host_rdata` one cycle after `host_rd`. The fields and their bit positions are:
  - 0x10: horizontal shrink factor, bits 23:0.
  - 0x14: vertical shrink factor, bits 23:0.
  - 0x18: first pixel in bits 11:0, last pixel in bits 27:16.
  - 0x1C: first line in bits 11:0, last line in bits 27:16.
  - 0x20: output pixels in bits 11:0, output lines in bits 27:16.
  - 0x24: horizontal coefficient set in bits 3:0, vertical coefficient set in bits 11:8.
  - 0x2C, 0x30, 0x34 and 0x38: horizontal luma, vertical luma, horizontal chroma and vertical chroma start phase, each in bits 20:0.
  All other bits read 0.
- R3: Writes to the shadow bank or to the control word never change any active output while no transfer takes place.
- R4: When vertical blanking rises while control bit 1 (update) is set, every active field takes the shadow value. In the same cycle control bit 1 clears to 0.
- R5: A rise of vertical blanking while the update bit is clear leaves all active outputs unchanged.
- R6: Vertical blanking held high for several cycles gives at most one transfer. An update requested during that interval is applied at the next rise.
- R7: `scale_enable` takes the value of control bit 0 only on a rise of vertical blanking. Writing the enable bit mid-frame has no visible effect until then.
- R8: The update-done interrupt (`irq_update`, and bit 5 of 0x08) goes to 1 in the transfer cycle. It stays at 1 while blanking lasts and returns to 0 on the first cycle blanking is seen low. Host writes to 0x08 have no effect on it.
- R9: Status bit 0 at 0x04 (`frame_done`) becomes 1 when blanking rises while `scale_enable` is 1. Any write to 0x04 clears it.
- R10: A host write that lands in the transfer cycle behaves as follows:
  - A shadow-bank write is stored in the shadow bank, and the active bank receives the value the shadow held before the write.
  - A control write with bit 1 set leaves a new pending request.
  - A status write does not cancel a `frame_done` that is set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid one cycle after host_rd |
| vblank | input | 1 | Vertical blanking from the video timing |
| scale_enable | output | 1 | Per-frame scaler enable |
| act_hsf | output | 24 | Active horizontal shrink factor |
| act_vsf | output | 24 | Active vertical shrink factor |
| act_px_first | output | 12 | Active aperture first pixel |
| act_px_last | output | 12 | Active aperture last pixel |
| act_ln_first | output | 12 | Active aperture first line |
| act_ln_last | output | 12 | Active aperture last line |
| act_out_px | output | 12 | Active output width |
| act_out_ln | output | 12 | Active output height |
| act_hset | output | 4 | Active horizontal coefficient set |
| act_vset | output | 4 | Active vertical coefficient set |
| act_ph_hy | output | 21 | Active horizontal luma start phase |
| act_ph_vy | output | 21 | Active vertical luma start phase |
| act_ph_hc | output | 21 | Active horizontal chroma start phase |
| act_ph_vc | output | 21 | Active vertical chroma start phase |
| frame_done | output | 1 | Frame-done status flag |
| irq_update | output | 1 | Level update-done interrupt |

## Verification
The host write port and the frame-boundary transfer can act in the same clock edge. The bench provokes this by raising `vblank` on exactly the cycle that carries a write strobe. It does this three times: with a write to a shrink-factor register, with a control write that sets the update bit, and with a status write while the enable is on. The results are judged at the ports:
- The active shrink factor must carry the pre-write shadow value, while a readback shows the newly written one.
- The control readback must still show a pending request, which the next blanking rise then consumes.
- `frame_done` must remain set despite the clearing write.

// File: rtl/scl_shadow_pkg.sv
`timescale 1ns/1ps
package scl_shadow_pkg;
  localparam int SF_W        = 24;
  localparam int PIX_W       = 12;
  localparam int LN_W        = 12;
  localparam int SET_W       = 4;
  localparam int PH_W        = 21;
  localparam int HI_LSB      = 16;
  localparam int SETV_LSB    = 8;
  localparam int UNITY_SHIFT = 20;
  localparam int IRQ_UPD_BIT = 5;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_IRQ  = 8'h08;
  localparam logic [7:0] A_HSF  = 8'h10;
  localparam logic [7:0] A_VSF  = 8'h14;
  localparam logic [7:0] A_APX  = 8'h18;
  localparam logic [7:0] A_ALN  = 8'h1C;
  localparam logic [7:0] A_OSZ  = 8'h20;
  localparam logic [7:0] A_SET  = 8'h24;
  localparam logic [7:0] A_PHY  = 8'h2C;
  localparam logic [7:0] A_PVY  = 8'h30;
  localparam logic [7:0] A_PHC  = 8'h34;
  localparam logic [7:0] A_PVC  = 8'h38;

  typedef struct packed {
    logic [SF_W-1:0]  hsf;
    logic [SF_W-1:0]  vsf;
    logic [PIX_W-1:0] px_first;
    logic [PIX_W-1:0] px_last;
    logic [LN_W-1:0]  ln_first;
    logic [LN_W-1:0]  ln_last;
    logic [PIX_W-1:0] out_px;
    logic [LN_W-1:0]  out_ln;
    logic [SET_W-1:0] hset;
    logic [SET_W-1:0] vset;
    logic [PH_W-1:0]  ph_hy;
    logic [PH_W-1:0]  ph_vy;
    logic [PH_W-1:0]  ph_hc;
    logic [PH_W-1:0]  ph_vc;
  } scl_params_t;

  // Pass-through scale, zero aperture, zero phases.
  function automatic scl_params_t params_reset();
    scl_params_t p;
    p     = '0;
    p.hsf = SF_W'(1 << UNITY_SHIFT);
    p.vsf = SF_W'(1 << UNITY_SHIFT);
    return p;
  endfunction

  function automatic logic in_shadow_range(input logic [7:0] a);
    return (a >= A_HSF) && (a <= A_PVC) && (a[1:0] == 2'b00);
  endfunction

  // Merge one host word into the parameter set.
  function automatic scl_params_t params_write(input scl_params_t p,
                                               input logic [7:0] a,
                                               input logic [31:0] d);
    scl_params_t q;
    q = p;
    case (a)
      A_HSF: q.hsf = d[SF_W-1:0];
      A_VSF: q.vsf = d[SF_W-1:0];
      A_APX: begin
        q.px_first = d[PIX_W-1:0];
        q.px_last  = d[HI_LSB +: PIX_W];
      end
      A_ALN: begin
        q.ln_first = d[LN_W-1:0];
        q.ln_last  = d[HI_LSB +: LN_W];
      end
      A_OSZ: begin
        q.out_px = d[PIX_W-1:0];
        q.out_ln = d[HI_LSB +: LN_W];
      end
      A_SET: begin
        q.hset = d[SET_W-1:0];
        q.vset = d[SETV_LSB +: SET_W];
      end
      A_PHY: q.ph_hy = d[PH_W-1:0];
      A_PVY: q.ph_vy = d[PH_W-1:0];
      A_PHC: q.ph_hc = d[PH_W-1:0];
      A_PVC: q.ph_vc = d[PH_W-1:0];
      default: ;
    endcase
    return q;
  endfunction

  // Host view of one parameter word; unused bits are zero.
  function automatic logic [31:0] params_read(input scl_params_t p,
                                              input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      A_HSF: r[SF_W-1:0] = p.hsf;
      A_VSF: r[SF_W-1:0] = p.vsf;
      A_APX: begin
        r[PIX_W-1:0]        = p.px_first;
        r[HI_LSB +: PIX_W]  = p.px_last;
      end
      A_ALN: begin
        r[LN_W-1:0]         = p.ln_first;
        r[HI_LSB +: LN_W]   = p.ln_last;
      end
      A_OSZ: begin
        r[PIX_W-1:0]        = p.out_px;
        r[HI_LSB +: LN_W]   = p.out_ln;
      end
      A_SET: begin
        r[SET_W-1:0]        = p.hset;
        r[SETV_LSB +: SET_W] = p.vset;
      end
      A_PHY: r[PH_W-1:0] = p.ph_hy;
      A_PVY: r[PH_W-1:0] = p.ph_vy;
      A_PHC: r[PH_W-1:0] = p.ph_hc;
      A_PVC: r[PH_W-1:0] = p.ph_vc;
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/scl_frame_sync.sv
`timescale 1ns/1ps
module scl_frame_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic vblank,
  output logic vb_q,
  output logic vb_rise,
  output logic vb_fall
);
  always_ff @(posedge clk) begin
    if (!rst_n) vb_q <= 1'b0;
    else        vb_q <= vblank;
  end

  assign vb_rise = vblank & ~vb_q;
  assign vb_fall = ~vblank & vb_q;
endmodule

// File: rtl/scl_host_regs.sv
`timescale 1ns/1ps
module scl_host_regs
  import scl_shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        vb_rise,
  input  logic        frame_done,
  input  logic        irq_update,
  output scl_params_t shadow,
  output logic        ctrl_enable,
  output logic        upd_req,
  output logic        xfer,
  output logic        stat_wr
);
  logic ctrl_wr;
  logic shadow_wr;

  assign ctrl_wr   = host_wr && (host_addr == A_CTRL);
  assign stat_wr   = host_wr && (host_addr == A_STAT);
  assign shadow_wr = host_wr && in_shadow_range(host_addr);
  assign xfer      = vb_rise && upd_req;

  // Control word: a host write wins over the self-clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_enable <= 1'b0;
      upd_req     <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_enable <= host_wdata[0];
      upd_req     <= host_wdata[1];
    end else if (xfer) begin
      upd_req     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         shadow <= params_reset();
    else if (shadow_wr) shadow <= params_write(shadow, host_addr, host_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      case (host_addr)
        A_CTRL:  host_rdata <= {30'b0, upd_req, ctrl_enable};
        A_STAT:  host_rdata <= {31'b0, frame_done};
        A_IRQ:   host_rdata <= 32'(irq_update) << IRQ_UPD_BIT;
        default: host_rdata <= params_read(shadow, host_addr);
      endcase
    end
  end

  // R4: the request is consumed by the transfer unless rewritten
  assert_upd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !ctrl_wr) |=> !upd_req);
  // R10: a control write that collides with the transfer keeps its request
  assert_collide_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ctrl_wr && host_wdata[1]) |=> upd_req);
endmodule

// File: rtl/scl_active_bank.sv
`timescale 1ns/1ps
module scl_active_bank
  import scl_shadow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vb_rise,
  input  logic        xfer,
  input  scl_params_t shadow,
  input  logic        ctrl_enable,
  output scl_params_t active,
  output logic        scale_enable
);
  always_ff @(posedge clk) begin
    if (!rst_n)    active <= params_reset();
    else if (xfer) active <= shadow;
  end

  // Enable is resampled on every frame boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)       scale_enable <= 1'b0;
    else if (vb_rise) scale_enable <= ctrl_enable;
  end

  // R3 / R5: the active set moves only with a transfer from the host block
  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(active));
  // R4: the shadow content seen at the transfer edge lands in the active set
  assert_active_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (active == $past(shadow)));
  // R7: enable changes only at a blanking rise
  assert_enable_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vb_rise |=> $stable(scale_enable));
endmodule

// File: rtl/scl_event_flags.sv
`timescale 1ns/1ps
module scl_event_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic vb_q,
  input  logic vb_rise,
  input  logic vb_fall,
  input  logic xfer,
  input  logic scale_enable,
  input  logic stat_wr,
  output logic frame_done,
  output logic irq_update
);
  // Setting wins over a host clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)                       frame_done <= 1'b0;
    else if (vb_rise && scale_enable) frame_done <= 1'b1;
    else if (stat_wr)                 frame_done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       irq_update <= 1'b0;
    else if (xfer)    irq_update <= 1'b1;
    else if (vb_fall) irq_update <= 1'b0;
  end

  // R8: the update interrupt is only ever high inside blanking
  assert_irq_in_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_update |-> vb_q);
  // R8: a transfer always raises the interrupt
  assert_irq_on_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> irq_update);
  // R9 / R10: end of an enabled frame sets the flag even against a clear
  assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_rise && scale_enable) |=> frame_done);
endmodule

// File: rtl/scl_shadow_ctrl.sv
`timescale 1ns/1ps
module scl_shadow_ctrl
  import scl_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              vblank,
  output logic              scale_enable,
  output logic [SF_W-1:0]   act_hsf,
  output logic [SF_W-1:0]   act_vsf,
  output logic [PIX_W-1:0]  act_px_first,
  output logic [PIX_W-1:0]  act_px_last,
  output logic [LN_W-1:0]   act_ln_first,
  output logic [LN_W-1:0]   act_ln_last,
  output logic [PIX_W-1:0]  act_out_px,
  output logic [LN_W-1:0]   act_out_ln,
  output logic [SET_W-1:0]  act_hset,
  output logic [SET_W-1:0]  act_vset,
  output logic [PH_W-1:0]   act_ph_hy,
  output logic [PH_W-1:0]   act_ph_vy,
  output logic [PH_W-1:0]   act_ph_hc,
  output logic [PH_W-1:0]   act_ph_vc,
  output logic              frame_done,
  output logic              irq_update
);
  logic        vb_q, vb_rise, vb_fall;
  logic        ctrl_enable, upd_req, xfer, stat_wr;
  scl_params_t shadow;
  scl_params_t active;

  scl_frame_sync u_sync (
    .clk(clk), .rst_n(rst_n), .vblank(vblank),
    .vb_q(vb_q), .vb_rise(vb_rise), .vb_fall(vb_fall)
  );

  scl_host_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .vb_rise(vb_rise), .frame_done(frame_done), .irq_update(irq_update),
    .shadow(shadow), .ctrl_enable(ctrl_enable), .upd_req(upd_req),
    .xfer(xfer), .stat_wr(stat_wr)
  );

  scl_active_bank u_bank (
    .clk(clk), .rst_n(rst_n), .vb_rise(vb_rise), .xfer(xfer),
    .shadow(shadow), .ctrl_enable(ctrl_enable),
    .active(active), .scale_enable(scale_enable)
  );

  scl_event_flags u_flags (
    .clk(clk), .rst_n(rst_n), .vb_q(vb_q), .vb_rise(vb_rise),
    .vb_fall(vb_fall), .xfer(xfer), .scale_enable(scale_enable),
    .stat_wr(stat_wr), .frame_done(frame_done), .irq_update(irq_update)
  );

  assign act_hsf      = active.hsf;
  assign act_vsf      = active.vsf;
  assign act_px_first = active.px_first;
  assign act_px_last  = active.px_last;
  assign act_ln_first = active.ln_first;
  assign act_ln_last  = active.ln_last;
  assign act_out_px   = active.out_px;
  assign act_out_ln   = active.out_ln;
  assign act_hset     = active.hset;
  assign act_vset     = active.vset;
  assign act_ph_hy    = active.ph_hy;
  assign act_ph_vy    = active.ph_vy;
  assign act_ph_hc    = active.ph_hc;
  assign act_ph_vc    = active.ph_vc;

  // R6: no two transfers on consecutive cycles of one blanking interval
  assert_one_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);
endmodule

// File: tb/tb_scl_shadow_ctrl.sv
`timescale 1ns/1ps
module tb_scl_shadow_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        vblank = 1'b0;
  logic        scale_enable, frame_done, irq_update;
  logic [23:0] act_hsf, act_vsf;
  logic [11:0] act_px_first, act_px_last, act_ln_first, act_ln_last, act_out_px, act_out_ln;
  logic [3:0]  act_hset, act_vset;
  logic [20:0] act_ph_hy, act_ph_vy, act_ph_hc, act_ph_vc;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  // Field order: hsf vsf pxf pxl lnf lnl opx oln hset vset phy pvy phc pvc
  int unsigned wid [14] = '{24,24,12,12,12,12,12,12,4,4,21,21,21,21};
  logic [31:0] sh  [14];
  logic [31:0] act [14];
  logic [31:0] rd;

  always #4 clk = ~clk;

  scl_shadow_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .vblank(vblank), .scale_enable(scale_enable),
    .act_hsf(act_hsf), .act_vsf(act_vsf),
    .act_px_first(act_px_first), .act_px_last(act_px_last),
    .act_ln_first(act_ln_first), .act_ln_last(act_ln_last),
    .act_out_px(act_out_px), .act_out_ln(act_out_ln),
    .act_hset(act_hset), .act_vset(act_vset),
    .act_ph_hy(act_ph_hy), .act_ph_vy(act_ph_vy),
    .act_ph_hc(act_ph_hc), .act_ph_vc(act_ph_vc),
    .frame_done(frame_done), .irq_update(irq_update)
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, a, e);
    end
  endtask

  function automatic logic [31:0] msk(input int unsigned w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic blank_rise;
    @(negedge clk); vblank = 1'b1;
    @(negedge clk);
  endtask

  task automatic blank_fall;
    @(negedge clk); vblank = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_active(input string tag);
    chk({tag, " hsf"},  32'(act_hsf),      act[0]);
    chk({tag, " vsf"},  32'(act_vsf),      act[1]);
    chk({tag, " pxf"},  32'(act_px_first), act[2]);
    chk({tag, " pxl"},  32'(act_px_last),  act[3]);
    chk({tag, " lnf"},  32'(act_ln_first), act[4]);
    chk({tag, " lnl"},  32'(act_ln_last),  act[5]);
    chk({tag, " opx"},  32'(act_out_px),   act[6]);
    chk({tag, " oln"},  32'(act_out_ln),   act[7]);
    chk({tag, " hset"}, 32'(act_hset),     act[8]);
    chk({tag, " vset"}, 32'(act_vset),     act[9]);
    chk({tag, " phy"},  32'(act_ph_hy),    act[10]);
    chk({tag, " pvy"},  32'(act_ph_vy),    act[11]);
    chk({tag, " phc"},  32'(act_ph_hc),    act[12]);
    chk({tag, " pvc"},  32'(act_ph_vc),    act[13]);
  endtask

  function automatic logic [31:0] word_of(input int r);
    case (r)
      0: return sh[0];
      1: return sh[1];
      2: return sh[2]  | (sh[3] << 16);
      3: return sh[4]  | (sh[5] << 16);
      4: return sh[6]  | (sh[7] << 16);
      5: return sh[8]  | (sh[9] << 8);
      6: return sh[10];
      7: return sh[11];
      8: return sh[12];
      default: return sh[13];
    endcase
  endfunction

  function automatic logic [7:0] addr_of(input int r);
    logic [7:0] t [10] = '{8'h10,8'h14,8'h18,8'h1C,8'h20,8'h24,8'h2C,8'h30,8'h34,8'h38};
    return t[r];
  endfunction

  // Fill the shadow set with pattern i; junk goes into unused bits.
  task automatic load_cfg(input int i);
    for (int k = 0; k < 14; k++)
      sh[k] = ((32'(i) * 32'h9E37_79B1) ^ (32'(k) * 32'h7F4A_7C15) ^ (32'h5A5 << i)) & msk(wid[k]);
    for (int r = 0; r < 10; r++) begin
      logic [31:0] junk;
      case (r)
        0, 1:    junk = 32'hFF00_0000;
        5:       junk = 32'hFFFF_F0F0;
        6, 7, 8, 9: junk = 32'hFFE0_0000;
        default: junk = 32'hF000_F000;
      endcase
      wr(addr_of(r), word_of(r) | junk);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 14; k++) begin sh[k] = 0; act[k] = 0; end
    sh[0] = 32'h0010_0000; sh[1] = 32'h0010_0000;
    act[0] = 32'h0010_0000; act[1] = 32'h0010_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_active("R1");
    chk("R1 enable", 32'(scale_enable), 0);
    chk("R1 done", 32'(frame_done), 0);
    chk("R1 irq", 32'(irq_update), 0);
    rdreg(8'h10, rd); chk("R1 shadow hsf", rd, 32'h0010_0000);
    rdreg(8'h14, rd); chk("R1 shadow vsf", rd, 32'h0010_0000);
    rdreg(8'h00, rd); chk("R1 ctrl", rd, 0);

    // Sweep of parameter patterns
    for (int i = 0; i < 6; i++) begin
      load_cfg(i);
      for (int r = 0; r < 10; r++) begin
        rdreg(addr_of(r), rd);
        chk($sformatf("R2 readback reg%0d pat%0d", r, i), rd, word_of(r));
      end
      rdreg(8'h28, rd); chk("R2 reserved word", rd, 0);
      check_active("R3 shadow-only");
      if (i % 2 == 1) begin
        blank_rise;
        check_active("R5 no request");
        chk("R5 irq", 32'(irq_update), 0);
        blank_fall;
      end
      wr(8'h00, 32'h2);
      check_active("R3 after ctrl");
      blank_rise;
      for (int k = 0; k < 14; k++) act[k] = sh[k];
      check_active("R4 transfer");
      chk("R8 irq set", 32'(irq_update), 1);
      if (i == 0) wr(8'h08, 32'hFFFF_FFFF);
      rdreg(8'h00, rd); chk("R4 update self-clear", rd, 0);
      rdreg(8'h08, rd); chk("R8 irq word", rd, 32'h20);
      chk("R8 irq held", 32'(irq_update), 1);
      blank_fall;
      chk("R8 irq cleared", 32'(irq_update), 0);
    end

    // R6: long blanking, one transfer only
    wr(8'h10, 32'h0012_3456); wr(8'h00, 32'h2);
    blank_rise;
    chk("R6 first transfer", 32'(act_hsf), 32'h0012_3456);
    wr(8'h10, 32'h0065_4321); wr(8'h00, 32'h2);
    repeat (3) @(negedge clk);
    chk("R6 no second transfer", 32'(act_hsf), 32'h0012_3456);
    blank_fall;
    chk("R6 still held", 32'(act_hsf), 32'h0012_3456);
    blank_rise;
    chk("R6 next rise", 32'(act_hsf), 32'h0065_4321);
    blank_fall;

    // R7 / R9 enable per frame and frame-done
    wr(8'h00, 32'h1);
    repeat (2) @(negedge clk);
    chk("R7 mid-frame enable", 32'(scale_enable), 0);
    blank_rise;
    chk("R7 enable at blank", 32'(scale_enable), 1);
    chk("R9 no done yet", 32'(frame_done), 0);
    blank_fall;
    blank_rise;
    chk("R9 done set", 32'(frame_done), 1);
    blank_fall;
    rdreg(8'h04, rd); chk("R9 status word", rd, 1);
    wr(8'h04, 32'h0000_DEAD);
    chk("R9 done cleared", 32'(frame_done), 0);
    wr(8'h00, 32'h0);
    chk("R7 mid-frame disable", 32'(scale_enable), 1);
    blank_rise;
    chk("R7 disable at blank", 32'(scale_enable), 0);
    chk("R9 last enabled frame", 32'(frame_done), 1);
    blank_fall;
    wr(8'h04, 32'h0);

    // R10: shadow write collides with transfer
    wr(8'h10, 32'h0011_1111); wr(8'h00, 32'h2);
    @(negedge clk);
    vblank = 1'b1; host_wr = 1'b1; host_addr = 8'h10; host_wdata = 32'h0022_2222;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R10 active gets old shadow", 32'(act_hsf), 32'h0011_1111);
    rdreg(8'h10, rd); chk("R10 shadow keeps write", rd, 32'h0022_2222);
    blank_fall;

    // R10: control write collides with transfer
    wr(8'h00, 32'h2);
    @(negedge clk);
    vblank = 1'b1; host_wr = 1'b1; host_addr = 8'h00; host_wdata = 32'h2;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R10 transfer done", 32'(act_hsf), 32'h0022_2222);
    rdreg(8'h00, rd); chk("R10 request still pending", rd, 32'h2);
    blank_fall;
    wr(8'h10, 32'h0033_3333);
    blank_rise;
    chk("R10 pending consumed", 32'(act_hsf), 32'h0033_3333);
    rdreg(8'h00, rd); chk("R10 ctrl cleared", rd, 0);
    blank_fall;

    // R10: status clear collides with frame-done set
    wr(8'h00, 32'h1);
    blank_rise; blank_fall;
    @(negedge clk);
    vblank = 1'b1; host_wr = 1'b1; host_addr = 8'h04; host_wdata = 32'h0;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R10 done survives clear", 32'(frame_done), 1);
    blank_fall;

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule